// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block inspects one tag entry read back from a four-way data cache and reports whether the entry is self-consistent. It pulls the 5-bit coherence state out of the high tag word and compares it against the six encodings a line may legally hold. A state outside that set is an error class of its own. For a legal state, two parity bits in the low tag word are recomputed over the two halves of the physical tag. The block also unpacks the set's replacement-order byte into four way numbers, ranked from least to most recently used. It rebuilds the line's physical address from the tag and the set index, and it forms the index-operation address that names the way.

A diagnostic sequencer presents the four ways of one set in turn on a valid/ready stream. It pulses `start` before or with the first way. The block keeps a sticky status word in cache-error status bit positions, so the result after the fourth way summarises the whole set. Each transfer is registered, so a result leaves one cycle after the tag is accepted. Back-pressure works like this: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output that is not taken stays unchanged until `out_ready` is seen high.

Top module: `dcache_tag_check`

## Requirements
- R1: The coherence state is tag-high bits 29:25 and is shown on `out_state`. `out_legal` is 1 exactly for 0x00 (invalid), 0x0F (shared coherent), 0x13 and 0x19 (non-coherent exclusive, clean and dirty), and 0x16 and 0x1C (coherent exclusive, clean and dirty).
- R2: A state outside the legal set sets bit 30 (state error) of `out_way_status`. Bits other than 30 and 29 of both status outputs are always 0.
- R3: For an illegal state the parity bits are ignored: bit 29 of `out_way_status` stays 0 even when both parity bits are wrong.
- R4: For a legal state, bit 29 (address error) of `out_way_status` is set when tag-low bit 11 differs from the XOR of tag-low bits 39:26, or tag-low bit 10 differs from the XOR of tag-low bits 25:13.
- R5: `out_phys_addr` is tag-low bits 39:13 placed above the 13-bit set index in bits 12:0.
- R6: `out_order` is tag-high bits 21:14, with rank 0 (least recently used) in bits 1:0 and rank 3 (most recently used) in bits 7:6. `out_lru_way` is rank 0 and `out_mru_way` is rank 3.
- R7: `out_op_addr` places the way number in bits 14:13 and the set index in bits 12:0.
- R8: A result appears with `out_valid` on the cycle after `in_valid && in_ready`. While `out_valid && !out_ready`, all outputs hold.
- R9: `in_ready` is high when `out_valid` is low or `out_ready` is high.
- R10: `out_status` is the OR of the `out_way_status` of every way accepted since the last `start`. A `start` in the same cycle as an accepted way clears the earlier ways, and that way's flags are kept.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and `out_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the sticky set status |
| in_valid | input | 1 | Tag entry present |
| in_ready | output | 1 | Tag entry accepted this cycle if valid |
| in_tag_hi | input | 32 | High tag word (state, replacement byte) |
| in_tag_lo | input | 64 | Low tag word (physical tag, parity bits) |
| in_index | input | 13 | Set index the tag was read from |
| in_way | input | 2 | Way the tag was read from |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_status | output | 32 | Sticky set status, bit 30 state error, bit 29 address error |
| out_way_status | output | 32 | Status of this way alone, same bit positions |
| out_state | output | 5 | Extracted coherence state |
| out_legal | output | 1 | State is one of the six legal encodings |
| out_phys_addr | output | 40 | Rebuilt physical line address |
| out_op_addr | output | 15 | Way and index as an index-operation address |
| out_order | output | 8 | Replacement ranks, LRU in bits 1:0 |
| out_lru_way | output | 2 | Least recently used way |
| out_mru_way | output | 2 | Most recently used way |

## Verification
A corrupted sticky accumulator shows on the very next transfer: `out_status` then no longer equals the OR of the per-way flags the bench expects since the last `start`. A stuck output-valid or hold register shows within one cycle as a missing, doubled or altered result under random `out_ready` stalls. A wrong legality decode or parity slice shows on the same transfer as a flipped bit 30 or 29. The cases that expose it are illegal states with bad parity and each legal state with either parity bit wrong.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int STATE_W = 5;
  localparam int STAT_W  = 32;
  localparam int ERR_STATE_BIT = 30;
  localparam int ERR_ADDR_BIT  = 29;

  typedef enum logic [STATE_W-1:0] {
    ST_INVALID       = 5'h00,
    ST_SHARED        = 5'h0F,
    ST_NC_EXCL_CLEAN = 5'h13,
    ST_NC_EXCL_DIRTY = 5'h19,
    ST_CO_EXCL_CLEAN = 5'h16,
    ST_CO_EXCL_DIRTY = 5'h1C
  } coh_state_e;
endpackage

// File: rtl/dct_state_decode.sv
module dct_state_decode
  import dct_pkg::*;
#(
  parameter int TAG_HI_W  = 32,
  parameter int STATE_LSB = 25
) (
  input  logic [TAG_HI_W-1:0] tag_hi,
  output logic [STATE_W-1:0]  state_o,
  output logic                legal_o
);
  logic unused_hi;
  assign unused_hi = ^tag_hi;

  always_comb begin
    state_o = tag_hi[STATE_LSB +: STATE_W];
    legal_o = state_o inside {ST_INVALID, ST_SHARED, ST_NC_EXCL_CLEAN,
                              ST_NC_EXCL_DIRTY, ST_CO_EXCL_CLEAN, ST_CO_EXCL_DIRTY};
  end
endmodule

// File: rtl/dct_tag_parity.sv
module dct_tag_parity #(
  parameter int TAG_LO_W = 64,
  parameter int PA_W     = 40,
  parameter int IDX_W    = 13,
  parameter int SPLIT    = 26,
  parameter int CHK_HI   = 11,
  parameter int CHK_LO   = 10
) (
  input  logic [TAG_LO_W-1:0] tag_lo,
  output logic                err_hi_o,
  output logic                err_lo_o
);
  logic unused_lo;
  assign unused_lo = ^tag_lo;

  always_comb begin
    err_hi_o = tag_lo[CHK_HI] ^ (^tag_lo[PA_W-1:SPLIT]);
    err_lo_o = tag_lo[CHK_LO] ^ (^tag_lo[SPLIT-1:IDX_W]);
  end
endmodule

// File: rtl/dct_repl_order.sv
module dct_repl_order #(
  parameter int TAG_HI_W = 32,
  parameter int WAYS     = 4,
  parameter int ORD_LSB  = 14,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ORD_W   = WAYS * WAY_W
) (
  input  logic [TAG_HI_W-1:0] tag_hi,
  output logic [ORD_W-1:0]    order_o,
  output logic [WAY_W-1:0]    lru_o,
  output logic [WAY_W-1:0]    mru_o
);
  logic unused_hi;
  assign unused_hi = ^tag_hi;

  for (genvar k = 0; k < WAYS; k++) begin : g_rank
    assign order_o[k*WAY_W +: WAY_W] = tag_hi[ORD_LSB + k*WAY_W +: WAY_W];
  end

  assign lru_o = order_o[0 +: WAY_W];
  assign mru_o = order_o[(WAYS-1)*WAY_W +: WAY_W];
endmodule

// File: rtl/dcache_tag_check.sv
module dcache_tag_check
  import dct_pkg::*;
#(
  parameter int TAG_HI_W  = 32,
  parameter int TAG_LO_W  = 64,
  parameter int PA_W      = 40,
  parameter int IDX_W     = 13,
  parameter int WAYS      = 4,
  parameter int STATE_LSB = 25,
  parameter int ORD_LSB   = 14,
  parameter int SPLIT     = 26,
  parameter int CHK_HI    = 11,
  parameter int CHK_LO    = 10,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int ORD_W    = WAYS * WAY_W,
  localparam int OP_W     = WAY_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [TAG_HI_W-1:0] in_tag_hi,
  input  logic [TAG_LO_W-1:0] in_tag_lo,
  input  logic [IDX_W-1:0]    in_index,
  input  logic [WAY_W-1:0]    in_way,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [STAT_W-1:0]   out_status,
  output logic [STAT_W-1:0]   out_way_status,
  output logic [STATE_W-1:0]  out_state,
  output logic                out_legal,
  output logic [PA_W-1:0]     out_phys_addr,
  output logic [OP_W-1:0]     out_op_addr,
  output logic [ORD_W-1:0]    out_order,
  output logic [WAY_W-1:0]    out_lru_way,
  output logic [WAY_W-1:0]    out_mru_way
);
  logic [STATE_W-1:0] state_c;
  logic               legal_c;
  logic               perr_hi, perr_lo;
  logic [ORD_W-1:0]   order_c;
  logic [WAY_W-1:0]   lru_c, mru_c;
  logic [STAT_W-1:0]  way_stat_c, acc_q, acc_next;
  logic [PA_W-1:0]    pa_c;
  logic               fire;

  dct_state_decode #(.TAG_HI_W(TAG_HI_W), .STATE_LSB(STATE_LSB)) u_decode (
    .tag_hi(in_tag_hi), .state_o(state_c), .legal_o(legal_c));

  dct_tag_parity #(.TAG_LO_W(TAG_LO_W), .PA_W(PA_W), .IDX_W(IDX_W), .SPLIT(SPLIT),
                   .CHK_HI(CHK_HI), .CHK_LO(CHK_LO)) u_parity (
    .tag_lo(in_tag_lo), .err_hi_o(perr_hi), .err_lo_o(perr_lo));

  dct_repl_order #(.TAG_HI_W(TAG_HI_W), .WAYS(WAYS), .ORD_LSB(ORD_LSB)) u_order (
    .tag_hi(in_tag_hi), .order_o(order_c), .lru_o(lru_c), .mru_o(mru_c));

  // Stream handshake: output register is a single slot.
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // Illegal state is its own class and masks the parity checks.
  always_comb begin
    way_stat_c = '0;
    way_stat_c[ERR_STATE_BIT] = !legal_c;
    way_stat_c[ERR_ADDR_BIT]  = legal_c && (perr_hi || perr_lo);
    pa_c = {in_tag_lo[PA_W-1:IDX_W], in_index};
    acc_next = (start ? '0 : acc_q) | (fire ? way_stat_c : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (start || fire) begin
      acc_q <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_status     <= '0;
      out_way_status <= '0;
      out_state      <= '0;
      out_legal      <= 1'b0;
      out_phys_addr  <= '0;
      out_op_addr    <= '0;
      out_order      <= '0;
      out_lru_way    <= '0;
      out_mru_way    <= '0;
    end else if (fire) begin
      out_valid      <= 1'b1;
      out_status     <= acc_next;
      out_way_status <= way_stat_c;
      out_state      <= state_c;
      out_legal      <= legal_c;
      out_phys_addr  <= pa_c;
      out_op_addr    <= {in_way, in_index};
      out_order      <= order_c;
      out_lru_way    <= lru_c;
      out_mru_way    <= mru_c;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

  // R8: a stalled result is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_status) &&
    $stable(out_way_status) && $stable(out_phys_addr));

  // R8: acceptance produces a result on the next cycle
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2: state error flag tracks the decoded legality
  a_r2_state_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_way_status[ERR_STATE_BIT] == !out_legal);

  // R3: no address error reported against an illegal state
  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_legal |-> !out_way_status[ERR_ADDR_BIT]);

  // R10: the set status contains every flag of the current way
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_way_status & ~out_status) == '0);

  // R2: only the two error positions are ever set
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_status & ~((STAT_W'(1) << ERR_STATE_BIT) |
                              (STAT_W'(1) << ERR_ADDR_BIT))) == 0);
endmodule

// File: tb/dcache_tag_check_bench.sv
`timescale 1ns/1ps
module dcache_tag_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_tag_hi = '0;
  logic [63:0] in_tag_lo = '0;
  logic [12:0] in_index = '0;
  logic [1:0]  in_way = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_status, out_way_status;
  logic [4:0]  out_state;
  logic        out_legal;
  logic [39:0] out_phys_addr;
  logic [14:0] out_op_addr;
  logic [7:0]  out_order;
  logic [1:0]  out_lru_way, out_mru_way;

  typedef struct {
    logic [31:0] status, way_status;
    logic [4:0]  state;
    logic        legal;
    logic [39:0] pa;
    logic [14:0] op;
    logic [7:0]  order;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] acc_model = '0;
  int          checks = 0, fails = 0;
  bit          rand_ready = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dcache_tag_check u_dcache_tag_check (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal_code(logic [4:0] s);
    return s == 5'h00 || s == 5'h0F || s == 5'h13 || s == 5'h19 ||
           s == 5'h16 || s == 5'h1C;
  endfunction

  // Driver: build a tag entry, push its expectation when accepted.
  task automatic send(logic [4:0] st, logic [7:0] ord, bit bad_hi, bit bad_lo,
                      logic [1:0] way, bit with_start);
    logic [31:0] hi;
    logic [63:0] lo;
    logic [12:0] idx;
    exp_t e;
    hi  = $urandom;
    lo  = {$urandom, $urandom};
    idx = 13'($urandom);
    hi[29:25] = st;
    hi[21:14] = ord;
    lo[11] = (^lo[39:26]) ^ bad_hi;
    lo[10] = (^lo[25:13]) ^ bad_lo;
    @(negedge clk);
    in_tag_hi = hi; in_tag_lo = lo; in_index = idx; in_way = way;
    in_valid = 1'b1; start = with_start;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e.legal = legal_code(st);
    e.state = st;
    e.way_status = '0;
    if (!e.legal) e.way_status[30] = 1'b1;
    else if (bad_hi || bad_lo) e.way_status[29] = 1'b1;
    if (with_start) acc_model = '0;
    acc_model = acc_model | e.way_status;
    e.status = acc_model;
    e.pa = {lo[39:13], idx};
    e.op = {way, idx};
    e.order = ord;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 1'b0; start = 1'b1;
    acc_model = '0;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) if (rand_ready) out_ready <= ($urandom % 4) != 0;

  // Monitor: the handshake completes at the next rising edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R1 state", 64'(out_state), 64'(e.state));
        chk("R1 legal", 64'(out_legal), 64'(e.legal));
        chk("R2/R3 state-error bit30", 64'(out_way_status[30]), 64'(e.way_status[30]));
        chk("R4/R3 addr-error bit29", 64'(out_way_status[29]), 64'(e.way_status[29]));
        chk("R2 way status word", 64'(out_way_status), 64'(e.way_status));
        chk("R10 set status", 64'(out_status), 64'(e.status));
        chk("R5 phys addr", 64'(out_phys_addr), 64'(e.pa));
        chk("R7 op addr", 64'(out_op_addr), 64'(e.op));
        chk("R6 order", 64'(out_order), 64'(e.order));
        chk("R6 lru", 64'(out_lru_way), 64'(e.order[1:0]));
        chk("R6 mru", 64'(out_mru_way), 64'(e.order[7:6]));
      end
    end
  end

  // R9: ready follows the output slot at every cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) chk("R9 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] legal_list[6];
    logic [4:0] bad_list[6];
    legal_list = '{5'h00, 5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};
    bad_list   = '{5'h01, 5'h1F, 5'h10, 5'h0E, 5'h14, 5'h1D};
    repeat (3) @(negedge clk);
    chk("R11 out_valid after reset", 64'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid", 64'(out_valid), 0);
    chk("R11 in_ready", 64'(in_ready), 1);
    chk("R11 status", 64'(out_status), 0);

    // R1/R4: every legal state, clean, then each parity half wrong
    pulse_start();
    for (int i = 0; i < 6; i++) begin
      send(legal_list[i], 8'hE4, 0, 0, 2'(i), 1);
      send(legal_list[i], 8'h1B, 1, 0, 2'(i + 1), 0);
      send(legal_list[i], 8'h4E, 0, 1, 2'(i + 2), 1);
      send(legal_list[i], 8'hB1, 1, 1, 2'(i + 3), 1);
    end
    // R3: illegal states with both parity bits broken
    for (int i = 0; i < 6; i++) send(bad_list[i], 8'h93, 1, 1, 2'(i), 1);
    // R10: accumulate over one set, then start clears
    pulse_start();
    send(5'h0F, 8'h27, 0, 0, 0, 0);
    send(5'h13, 8'h27, 1, 0, 1, 0);
    send(5'h19, 8'h27, 0, 0, 2, 0);
    send(5'h05, 8'h27, 0, 0, 3, 0);
    pulse_start();
    send(5'h16, 8'hD8, 0, 0, 0, 0);
    send(5'h1C, 8'hD8, 0, 0, 1, 1);
    idle();

    // R8/R9: random stalls and random traffic
    rand_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [4:0] s;
      s = ($urandom % 2) ? legal_list[$urandom % 6] : 5'($urandom);
      send(s, 8'($urandom), bit'($urandom), bit'($urandom), 2'(n), ($urandom % 5) == 0);
      if ((n % 37) == 0) idle();
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    rand_ready = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule